// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous static RAM that serves as the data store of a processor's secondary cache. It holds 18-bit words split into two 9-bit lanes. A 16-bit word address selects a word. The array depth is set by a parameter, so a simulation can use a short array; the upper address bits beyond that depth are then not decoded. Every input except the output enable is captured on the rising clock edge. The word read in a cycle is placed in an output register at the following edge.

A burst begins when one of two address strobes loads an external address. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the lane write enables. Each later beat that has the advance input asserted steps a 2-bit counter. The two low address bits are the starting low bits XOR the count, which is an interleaved order. The bus is modelled as separate data-in and data-out ports and a drive-enable port. The drive enable follows the output enable directly, with no clock involved.

Top module: `sburst_sram`

## Requirements
- R1: A read presents its word on `dq_out` one clock edge after the edge that captured it. Before that edge, `dq_out` still shows the previous result.
- R2: When `ce_n`=0 and either `adsp_n` or `adsc_n` is 0, the cycle uses the `addr` input and restarts the burst count at 0.
- R3: In a cycle with `ce_n`=0, both strobes at 1 and `adv_n`=0, the count steps by one. The low two address bits are then the loaded start bits XOR the count, so a start of 2 gives 2,3,0,1 and a start of 3 gives 3,2,1,0.
- R4: The count wraps after four beats, and address bits 15:2 stay at the loaded value during a burst.
- R5: In a cycle with `ce_n`=0, both strobes at 1 and `adv_n`=1, the cycle uses the same address as the previous cycle, for a read or for a write.
- R6: `we_n[0]`=0 writes bits 8:0 and `we_n[1]`=0 writes bits 17:9. A lane whose enable is 1 keeps its stored value.
- R7: If `adsp_n`=0, the cycle is a read regardless of `we_n` and `adsc_n`.
- R8: A read of an address that the immediately preceding cycle wrote returns the new data.
- R9: `dq_oe` = 1 exactly when `oe_n` = 0, and it changes without a clock edge.
- R10: A synchronous active-high `rst` clears the output register to 0 and the burst state to address 0 with count 0.
- R11: A cycle with `ce_n`=1 writes nothing, does not change `dq_out` and leaves the burst state alone.
- R12: A write cycle leaves `dq_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor-side burst start strobe (read only), active low, has priority |
| adsc_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 2 | Lane write enables, active low; bit 0 covers bits 8:0, bit 1 covers bits 17:9 |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 16 | Word address |
| dq_in | input | 18 | Write data |
| dq_out | output | 18 | Registered read data |
| dq_oe | output | 1 | Drive enable for the external data bus |

## Verification
The hardest case to reach from the ports is a burst that starts at an odd or unaligned offset and wraps back to a word that the same burst overwrote on its fifth write beat. Reaching it needs a controlled history of writes followed by reads that step across the wrap point. The stimulus first fills four words with a write burst and adds one more write beat, so the wrap overwrites the first word. It then reads that word on the next cycle through the processor-side strobe, which also tests read-after-write. After that it runs read bursts from starts 0, 2, 3 and 1 over the same four words, so each of them has a known value. A cycle with both strobes asserted and both lane enables asserted is followed by a hold read, which shows at the ports that nothing was written.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
    localparam int ADDR_W  = 16;
    localparam int LANE_W  = 9;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int BURST_W = 2;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [LANES-1:0]   lane_t;
    typedef logic [BURST_W-1:0] step_t;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        addr_t     addr;
        cyc_kind_e kind;
        lane_t     lane_en;
        data_t     wdata;
    } cyc_t;

    // Interleaved order: low bits of the start address XOR the beat count.
    function automatic addr_t burst_addr(input addr_t base, input step_t step);
        addr_t a;
        a = base;
        a[BURST_W-1:0] = base[BURST_W-1:0] ^ step;
        return a;
    endfunction
endpackage

// File: rtl/sburst_addr_gen.sv
module sburst_addr_gen
    import sburst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  load,
    input  logic  adv,
    input  addr_t addr_in,
    output addr_t cur_addr
);
    addr_t base_q, base_nxt;
    step_t cnt_q, cnt_nxt;

    always_comb begin
        base_nxt = base_q;
        cnt_nxt  = cnt_q;
        if (sel && load) begin
            base_nxt = addr_in;
            cnt_nxt  = '0;
        end else if (sel && adv) begin
            cnt_nxt  = cnt_q + step_t'(1);
        end
        cur_addr = burst_addr(base_nxt, cnt_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            base_q <= base_nxt;
            cnt_q  <= cnt_nxt;
        end
    end
endmodule

// File: rtl/sburst_array.sv
module sburst_array
    import sburst_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  cyc_t  cyc,
    output data_t rdata_q
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [MEM_AW-1:0] idx;
    assign idx = cyc.addr[MEM_AW-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (cyc.kind == CYC_WRITE && cyc.lane_en[l])
                mem[idx] <= cyc.wdata[l*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (cyc.kind == CYC_READ)
                lane_q <= mem[idx];
        end

        assign rdata_q[l*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sburst_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce_n,
    input  logic                 adsp_n,
    input  logic                 adsc_n,
    input  logic                 adv_n,
    input  logic [LANES-1:0]     we_n,
    input  logic                 oe_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    dq_in,
    output logic [DATA_W-1:0]    dq_out,
    output logic                 dq_oe
);
    logic  sel, proc_start, ctrl_start, load, step;
    addr_t cur_addr;
    lane_t lane_en;
    cyc_t  cyc_d, cyc_q;

    assign sel        = ~ce_n;
    assign proc_start = ~adsp_n;
    assign ctrl_start = ~adsc_n;
    assign load       = proc_start | ctrl_start;
    assign step       = ~adv_n & ~load;
    // The processor strobe forces a read: lane enables are dropped.
    assign lane_en    = proc_start ? '0 : ~we_n;

    sburst_addr_gen u_agen (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .load     (load),
        .adv      (step),
        .addr_in  (addr),
        .cur_addr (cur_addr)
    );

    always_comb begin
        cyc_d.addr    = cur_addr;
        cyc_d.lane_en = lane_en;
        cyc_d.wdata   = dq_in;
        if (!sel)
            cyc_d.kind = CYC_IDLE;
        else if (|lane_en)
            cyc_d.kind = CYC_WRITE;
        else
            cyc_d.kind = CYC_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '{addr: '0, kind: CYC_IDLE, lane_en: '0, wdata: '0};
        end else begin
            cyc_q <= cyc_d;
        end
    end

    sburst_array #(.MEM_AW(MEM_AW)) u_array (
        .clk     (clk),
        .rst     (rst),
        .cyc     (cyc_q),
        .rdata_q (dq_out)
    );

    assign dq_oe = ~oe_n;
endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk
    import sburst_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ce_n,
    input logic             adsp_n,
    input logic             adsc_n,
    input logic             adv_n,
    input logic [LANES-1:0] we_n,
    input addr_t            addr,
    input data_t            dq_out,
    input logic             wr_q,
    input addr_t            cyc_addr
);
    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && (!adsp_n || !adsc_n)) |=> cyc_addr == $past(addr));

    // R3
    adv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adsp_n && adsc_n && !adv_n) |=>
        cyc_addr[BURST_W-1:0] != $past(cyc_addr[BURST_W-1:0]));

    // R4
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (adsp_n && adsc_n) |=>
        cyc_addr[ADDR_W-1:BURST_W] == $past(cyc_addr[ADDR_W-1:BURST_W]));

    // R7
    proc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !adsp_n) |=> !wr_q);

    // R10
    reset_out_chk: assert property (@(posedge clk)
        $past(rst) |-> dq_out == '0);

    // R11
    desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> ##1 $stable(dq_out));

    // R12
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && adsp_n && we_n != '1) |=> ##1 $stable(dq_out));
endmodule

bind sburst_sram sburst_sram_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .we_n     (we_n),
    .addr     (addr),
    .dq_out   (dq_out),
    .wr_q     (cyc_q.kind == sburst_pkg::CYC_WRITE),
    .cyc_addr (cyc_q.addr)
);

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb_top;
    import sburst_pkg::*;

    typedef struct packed {
        logic        ce_n;
        logic        adsp_n;
        logic        adsc_n;
        logic        adv_n;
        logic [1:0]  we_n;
        logic [15:0] a;
        logic [17:0] d;
        logic [17:0] e;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(logic c, logic p, logic s, logic v, logic [1:0] w,
                                logic [15:0] a, logic [17:0] d, logic [17:0] e,
                                logic [3:0] r);
        return '{ce_n: c, adsp_n: p, adsc_n: s, adv_n: v, we_n: w,
                  a: a, d: d, e: e, req: r};
    endfunction

    localparam int NV = 34;
    // e = expected dq_out after the cycle's result has been registered
    localparam vec_t VECS [NV] = '{
        mk(0,1,0,1,2'b00,16'h20,18'h12345,18'h0,    4'd12),
        mk(0,1,1,0,2'b00,16'h0, 18'h00111,18'h0,    4'd12),
        mk(0,1,1,0,2'b00,16'h0, 18'h00222,18'h0,    4'd12),
        mk(0,1,1,0,2'b00,16'h0, 18'h00333,18'h0,    4'd12),
        mk(0,1,1,0,2'b00,16'h0, 18'h3FFFF,18'h0,    4'd12),
        mk(0,0,1,1,2'b11,16'h20,18'h0,    18'h3FFFF,4'd8),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00111,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00222,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00333,4'd3),
        mk(0,1,0,1,2'b11,16'h22,18'h0,    18'h00222,4'd2),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00333,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h3FFFF,4'd4),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00111,4'd3),
        mk(0,1,1,1,2'b11,16'h0, 18'h0,    18'h00111,4'd5),
        mk(0,1,0,1,2'b10,16'h23,18'h3FFFF,18'h00111,4'd12),
        mk(0,1,1,1,2'b11,16'h0, 18'h0,    18'h003FF,4'd6),
        mk(0,1,1,1,2'b01,16'h0, 18'h0,    18'h003FF,4'd12),
        mk(0,1,1,1,2'b11,16'h0, 18'h0,    18'h001FF,4'd6),
        mk(0,0,0,1,2'b00,16'h22,18'h0AAAA,18'h00222,4'd7),
        mk(0,1,1,1,2'b11,16'h0, 18'h0,    18'h00222,4'd7),
        mk(0,1,0,1,2'b00,16'h30,18'h15555,18'h00222,4'd12),
        mk(0,1,1,1,2'b00,16'h0, 18'h2AAAA,18'h00222,4'd5),
        mk(0,1,0,1,2'b11,16'h30,18'h0,    18'h2AAAA,4'd5),
        mk(0,1,0,1,2'b11,16'h23,18'h0,    18'h001FF,4'd2),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00222,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00111,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h3FFFF,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h001FF,4'd4),
        mk(0,1,0,1,2'b11,16'h21,18'h0,    18'h00111,4'd2),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h3FFFF,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h001FF,4'd3),
        mk(0,1,1,0,2'b11,16'h0, 18'h0,    18'h00222,4'd3),
        mk(1,1,0,1,2'b00,16'h21,18'h0,    18'h00222,4'd11),
        mk(0,1,0,1,2'b11,16'h21,18'h0,    18'h00111,4'd11)
    };

    function automatic string req_name(logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
    logic [1:0]  we_n = 2'b11;
    logic [15:0] addr = '0;
    logic [17:0] dq_in = '0;
    logic [17:0] dq_out;
    logic        dq_oe;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    sburst_sram dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        ce_n = v.ce_n; adsp_n = v.adsp_n; adsc_n = v.adsc_n; adv_n = v.adv_n;
        we_n = v.we_n; addr = v.a; dq_in = v.d;
    endtask

    task automatic idle();
        ce_n = 1'b1; adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        we_n = 2'b11; addr = '0; dq_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: output register cleared by reset
        chk("R10", dq_out, 18'h0);
        chk("R9", {17'h0, dq_oe}, 18'h1);

        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) chk(req_name(VECS[i-2].req), dq_out, VECS[i-2].e);
            if (i < NV) drive(VECS[i]);
            else idle();
        end

        // R1: one edge of latency; old value visible before that edge
        @(negedge clk);
        drive(mk(0,1,0,1,2'b11,16'h20,18'h0,18'h0,4'd1));
        @(negedge clk);
        idle();
        chk("R1", dq_out, 18'h00111);
        @(negedge clk);
        chk("R1", dq_out, 18'h3FFFF);

        // R9: drive enable follows oe_n between clock edges
        #1 oe_n = 1'b1;
        #0.5 chk("R9", {17'h0, dq_oe}, 18'h0);
        oe_n = 1'b0;
        #0.5 chk("R9", {17'h0, dq_oe}, 18'h1);

        // R10: reset in mid-operation clears the output
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10", dq_out, 18'h0);

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule